// File: doc/BRIEF.md
# Single-Shot Pulse Timer

This timer channel emits exactly one pulse per start event on an output pin. The pulse is framed by an internal run flag. Software can raise the flag with a set strobe. A rising edge on an external trigger pin can also raise it. When the flag rises, a tick counter restarts from zero and the output goes to its active level. The flag drops when software issues a clear strobe. It also drops when the counter equals the programmed compare-A value on a tick, so the compare-A register sets the pulse width. That match also raises a sticky interrupt flag.

The channel works only when its mode field and its I/O-control field select single-pulse operation. In any other setting the output rests at its idle level and start requests are ignored. The period compare register and the counter-clear select bit are wired in as inputs but have no influence here. A polarity input inverts the pin, and a second pin always carries the inverse of the first.

Top module: `oneshot_timer`

## Requirements
- R1: Operation is enabled only when mode_i equals 2'b10 and io_sel_i equals 2'b11. Otherwise set strobes and trigger edges are ignored, and a pulse in progress ends on the next clock edge.
- R2: A sw_set_i strobe while idle makes the output active from the next clock edge, with the tick counter restarted at zero.
- R3: A 0-to-1 change on trig_i passes a two-flop synchronizer and edge detector, so the output becomes active on the third clock edge after the change. A trigger held high does not start a second pulse.
- R4: A set strobe or trigger edge that arrives while a pulse is active is ignored: it neither restarts the counter nor stretches the pulse.
- R5: The counter advances only on cycles with tick_i high while a pulse is active. A pulse lasts cmpa_i+1 ticks, so a compare-A value of zero gives a one-tick pulse.
- R6: A compare-A match, which is a tick while active with the counter equal to cmpa_i, ends the pulse on that clock edge.
- R7: A sw_clr_i strobe during a pulse ends it on the next clock edge and does not set the interrupt.
- R8: A compare-A match sets irq_o. irq_o stays high until an irq_clr_i strobe, which clears it on the next edge unless a match occurs in the same cycle.
- R9: With pol_inv_i low, pulse_o is high while active. With pol_inv_i high, pulse_o is low while active. pulse_n_o is always the inverse of pulse_o.
- R10: period_i and cclr_sel_i have no effect on pulse start, width or interrupt.
- R11: While rst_n is low, the channel is idle, pulse_o sits at the level set by pol_inv_i, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter clock enable |
| mode_i | input | 2 | Timer mode field (2'b10 selects single pulse) |
| io_sel_i | input | 2 | Output control field (2'b11 selects single pulse) |
| cmpa_i | input | CNT_W | Compare-A value, sets the pulse width |
| period_i | input | CNT_W | Period compare value, unused in this mode |
| cclr_sel_i | input | 1 | Counter-clear select, unused in this mode |
| sw_set_i | input | 1 | Software start strobe |
| sw_clr_i | input | 1 | Software stop strobe |
| trig_i | input | 1 | Asynchronous external trigger pin |
| pol_inv_i | input | 1 | Output polarity, 1 gives active-low |
| irq_clr_i | input | 1 | Interrupt clear strobe (write one to clear) |
| pulse_o | output | 1 | Pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |
| irq_o | output | 1 | Sticky compare-A interrupt flag |

## Verification
The hardest case to reach is a start request that lands while a pulse is already running. In that case the counter must not be restarted. The only visible sign is the pulse width measured in ticks. The bench starts a long pulse, then fires both a set strobe and a trigger edge part way through. The trigger edge reaches the run flag several cycles later through the synchronizer. The bench then confirms that the total tick count during the active phase is still exactly the compare value plus one. Widths are also swept across compare values at several tick densities, and the expected widths are counted arithmetically.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;

   localparam logic [1:0] MODE_SINGLE = 2'b10;
   localparam logic [1:0] IO_SINGLE   = 2'b11;

   typedef enum logic {
      RUN_IDLE   = 1'b0,
      RUN_ACTIVE = 1'b1
   } run_state_t;

   function automatic logic single_mode(input logic [1:0] mode, input logic [1:0] io);
      return (mode == MODE_SINGLE) && (io == IO_SINGLE);
   endfunction

endpackage

// File: rtl/oneshot_trig_sync.sv
module oneshot_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES:0] sh_q;

   initial begin
      if (STAGES < 2) $fatal(1, "oneshot_trig_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[g] <= 1'b0;
            else        sh_q[g] <= sh_q[g-1];
         end
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/oneshot_pulse_cnt.sv
module oneshot_pulse_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   initial begin
      if (CNT_W < 2) $fatal(1, "oneshot_pulse_cnt: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_o <= '0;
      else if (restart_i) cnt_o <= '0;
      else if (adv_i)     cnt_o <= cnt_o + ONE;
   end

   assign match_o = adv_i && (cnt_o == cmp_i);

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
   import oneshot_timer_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       io_sel_i,
   input  logic [CNT_W-1:0] cmpa_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             cclr_sel_i,
   input  logic             sw_set_i,
   input  logic             sw_clr_i,
   input  logic             trig_i,
   input  logic             pol_inv_i,
   input  logic             irq_clr_i,
   output logic             pulse_o,
   output logic             pulse_n_o,
   output logic             irq_o
);

   run_state_t       run_q;
   logic             sel;
   logic             active;
   logic             trig_rise;
   logic             start;
   logic             stop;
   logic             adv;
   logic             match;
   logic [CNT_W-1:0] cnt_q;
   logic             unused_ign;

   assign unused_ign = ^{period_i, cclr_sel_i};

   oneshot_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (trig_i),
      .rise_o (trig_rise)
   );

   assign sel    = single_mode(mode_i, io_sel_i);
   assign active = (run_q == RUN_ACTIVE);
   assign start  = sel && !active && (sw_set_i || trig_rise);
   assign adv    = active && tick_i;

   oneshot_pulse_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (start),
      .adv_i     (adv),
      .cmp_i     (cmpa_i),
      .cnt_o     (cnt_q),
      .match_o   (match)
   );

   assign stop = active && (sw_clr_i || match);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run_q <= RUN_IDLE;
      else if (!sel)  run_q <= RUN_IDLE;
      else if (start) run_q <= RUN_ACTIVE;
      else if (stop)  run_q <= RUN_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_o <= 1'b0;
      else if (match)     irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
   end

   assign pulse_o   = active ^ pol_inv_i;
   assign pulse_n_o = ~pulse_o;

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic [1:0]       mode_i,
   input logic [1:0]       io_sel_i,
   input logic [CNT_W-1:0] cmpa_i,
   input logic             sw_clr_i,
   input logic             irq_clr_i,
   input logic             irq_o,
   input logic             active,
   input logic [CNT_W-1:0] cnt
);

   logic hit;
   assign hit = active && tick_i && (cnt == cmpa_i);

   // R2
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (cnt == '0));

   // R6
   match_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !active);

   // R8
   match_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> irq_o);

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o);

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr_i && !hit) |=> !irq_o);

   // R7
   sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sw_clr_i) |=> !active);

   // R1
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_i == 2'b10 && io_sel_i == 2'b11) |=> !active);

   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && tick_i) |=> ($rose(active) || $stable(cnt)));

endmodule

bind oneshot_timer oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .mode_i    (mode_i),
   .io_sel_i  (io_sel_i),
   .cmpa_i    (cmpa_i),
   .sw_clr_i  (sw_clr_i),
   .irq_clr_i (irq_clr_i),
   .irq_o     (irq_o),
   .active    (active),
   .cnt       (cnt_q)
);

// File: tb/oneshot_timer_bench.sv
`timescale 1ns/1ps
module oneshot_timer_bench;

   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b1;
   logic [1:0]    mode = 2'b10;
   logic [1:0]    io_sel = 2'b11;
   logic [CW-1:0] cmpa = '0;
   logic [CW-1:0] period = '0;
   logic          cclr_sel = 1'b0;
   logic          sw_set = 1'b0;
   logic          sw_clr = 1'b0;
   logic          trig = 1'b0;
   logic          pol_inv = 1'b0;
   logic          irq_clr = 1'b0;
   logic          pulse, pulse_n, irq;

   int n_chk = 0;
   int n_fail = 0;
   int tdiv = 1;
   int tph = 0;
   bit done = 0;

   always #5 clk = ~clk;

   oneshot_timer #(.CNT_W(CW), .SYNC_STAGES(2)) u_oneshot_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .io_sel_i(io_sel),
      .cmpa_i(cmpa), .period_i(period), .cclr_sel_i(cclr_sel),
      .sw_set_i(sw_set), .sw_clr_i(sw_clr), .trig_i(trig), .pol_inv_i(pol_inv),
      .irq_clr_i(irq_clr), .pulse_o(pulse), .pulse_n_o(pulse_n), .irq_o(irq)
   );

   initial begin
      forever begin
         @(posedge clk);
         #1;
         tph = (tph + 1) % tdiv;
         tick = (tph == 0);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit is_act();
      return pulse ^ pol_inv;
   endfunction

   task automatic clear_irq();
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
   endtask

   task automatic do_pulse(input int cv, output int ticks, output bit started);
      int guard;
      cmpa = CW'(cv);
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      started = is_act();
      ticks = 0;
      guard = 0;
      while (is_act() && guard < 5000) begin
         if (tick) ticks++;
         @(negedge clk);
         guard++;
      end
   endtask

   initial begin
      int  ticks;
      bit  st;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(pulse == 1'b0, "R11 pulse idle in reset", pulse, 0);
      chk(pulse_n == 1'b1, "R11 pulse_n in reset", pulse_n, 1);
      chk(irq == 1'b0, "R11 irq low in reset", irq, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 R6 R8 width sweep over compare values and tick densities
      for (int d = 1; d <= 3; d++) begin
         tdiv = d;
         for (int cv = 0; cv <= 20; cv++) begin
            clear_irq();
            do_pulse(cv, ticks, st);
            chk(st, "R2 start by sw_set", st, 1);
            chk(ticks == cv + 1, "R5 pulse width in ticks", ticks, cv + 1);
            chk(!is_act(), "R6 match ends pulse", is_act(), 0);
            chk(irq == 1'b1, "R8 irq set by match", irq, 1);
         end
      end
      tdiv = 1;

      // R8 sticky and cleared
      repeat (4) @(negedge clk);
      chk(irq == 1'b1, "R8 irq sticky", irq, 1);
      clear_irq();
      chk(irq == 1'b0, "R8 irq cleared", irq, 0);

      // R10 ignored period and clear-select
      for (int k = 0; k < 8; k++) begin
         period = CW'(k * 37);
         cclr_sel = k[0];
         do_pulse(k + 3, ticks, st);
         chk(st && ticks == k + 4, "R10 unused fields no effect", ticks, k + 4);
      end
      clear_irq();

      // R3 trigger latency and edge-only behaviour
      cmpa = 6;
      @(negedge clk) trig = 1'b1;
      @(negedge clk);
      chk(!is_act(), "R3 not active after 1 edge", is_act(), 0);
      @(negedge clk);
      chk(!is_act(), "R3 not active after 2 edges", is_act(), 0);
      @(negedge clk);
      chk(is_act(), "R3 active after 3 edges", is_act(), 1);
      ticks = 0;
      while (is_act()) begin
         if (tick) ticks++;
         @(negedge clk);
      end
      chk(ticks == 7, "R3 trigger pulse width", ticks, 7);
      repeat (10) @(negedge clk);
      chk(!is_act(), "R3 held trigger no restart", is_act(), 0);
      trig = 1'b0;
      repeat (4) @(negedge clk);

      // R4 restart requests during active pulse are ignored
      cmpa = 10;
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      ticks = 0;
      for (int i = 0; i < 200 && is_act(); i++) begin
         if (tick) ticks++;
         if (i == 3) begin sw_set = 1'b1; trig = 1'b1; end
         @(negedge clk);
         if (i == 3) sw_set = 1'b0;
      end
      chk(ticks == 11, "R4 restart ignored while active", ticks, 11);
      repeat (5) @(negedge clk);
      chk(!is_act(), "R4 no second pulse", is_act(), 0);
      trig = 1'b0;
      repeat (4) @(negedge clk);
      clear_irq();

      // R7 software clear
      cmpa = 100;
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      repeat (5) @(negedge clk);
      chk(is_act(), "R7 pulse running", is_act(), 1);
      sw_clr = 1'b1;
      @(negedge clk) sw_clr = 1'b0;
      chk(!is_act(), "R7 sw_clr ends pulse", is_act(), 0);
      chk(irq == 1'b0, "R7 no irq on sw_clr", irq, 0);

      // R1 mode gating
      mode = 2'b01;
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      repeat (2) @(negedge clk);
      chk(!is_act(), "R1 wrong mode ignores set", is_act(), 0);
      mode = 2'b10;
      io_sel = 2'b10;
      @(negedge clk) trig = 1'b1;
      repeat (5) @(negedge clk);
      chk(!is_act(), "R1 wrong io ignores trigger", is_act(), 0);
      trig = 1'b0;
      io_sel = 2'b11;
      repeat (4) @(negedge clk);
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      repeat (3) @(negedge clk);
      chk(is_act(), "R1 pulse running before mode change", is_act(), 1);
      mode = 2'b00;
      @(negedge clk);
      chk(!is_act(), "R1 leaving mode ends pulse", is_act(), 0);
      mode = 2'b10;
      repeat (2) @(negedge clk);

      // R9 inverted polarity
      pol_inv = 1'b1;
      @(negedge clk);
      chk(pulse == 1'b1 && pulse_n == 1'b0, "R9 idle level inverted", pulse, 1);
      cmpa = 4;
      @(negedge clk) sw_set = 1'b1;
      @(negedge clk) sw_set = 1'b0;
      chk(pulse == 1'b0 && pulse_n == 1'b1, "R9 active-low pulse", pulse, 0);
      ticks = 0;
      while (pulse == 1'b0) begin
         if (tick) ticks++;
         @(negedge clk);
      end
      chk(ticks == 5, "R9 inverted width", ticks, 5);
      chk(pulse_n == ~pulse, "R9 complement after pulse", pulse_n, ~pulse);
      pol_inv = 1'b0;
      @(negedge clk);
      chk(pulse == 1'b0 && pulse_n == 1'b1, "R9 normal idle", pulse, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule